// File: doc/BRIEF.md
# Sampled-Stream Duty and Edge Evaluator

This block evaluates bit streams that have already been captured into a synchronous sample memory. Each memory word holds one sample from every channel, and each channel is one bit lane across consecutive words. After a start pulse, the block walks a programmable address window one word per cycle. For every lane it counts the samples at logic one and the level changes between consecutive samples.

The outputs are a ones count and a transition count for each lane, plus the sample count n. Software or downstream logic can form the duty cycle as ones/n and the relative zone frequency as transitions/(n-1). A flag for each lane marks a duty cycle too far from one half for frequency work.

A final stage takes one selected lane and a given Nyquist zone number. It converts that lane's transition ratio into a folded frequency in fixed point. Moving the window over the same stored data lets the start-up and steady parts of a capture be examined separately.

Top module: `stream_edge_eval`

## Requirements
- R1: After an accepted start, `rd_en` is high for exactly n consecutive cycles. `rd_addr` steps by one from `win_first` to `win_last`, wrapping from 2^AW-1 to 0. Read data is taken on `rd_data` one cycle after each read cycle.
- R2: The sample count `n_cnt` equals ((win_last - win_first) mod 2^AW) + 1. A window whose last address is one below its first address covers all 2^AW words.
- R3: For every lane c, bit c of each word is that lane's sample. The field `ones_cnt[c*CW +: CW]` holds the number of window samples equal to 1.
- R4: The field `trans_cnt[c*CW +: CW]` is the sum over j=2..n of x_j XOR x_(j-1) in window order. The first sample contributes nothing, and changes between adjacent words are counted.
- R5: `res_valid` falls in the cycle after an accepted start. The counts and `res_valid` change together at the clock edge that ends the cycle carrying the last read data, so they are visible n+2 cycles after the start edge. They then hold until the next accepted start.
- R6: A start pulse while `busy` is high is ignored: the running evaluation finishes with its original window, zone and lane selection.
- R7: `dc_off[c]` is 1 exactly when 100*ones < 47*n or 100*ones > 53*n for lane c, using the current results.
- R8: After the results, `freq_valid` rises with `freq` set to the folded frequency of lane `fsel`, in units of fs/2 with FRAC fractional bits. With q = floor(transitions*2^FRAC/(n-1)), `freq` is k*2^FRAC + q for an even zone k and (k+1)*2^FRAC - q for an odd zone k.
- R9: With n = 1, q is taken as 0, so `freq` is k*2^FRAC for even k and (k+1)*2^FRAC for odd k.
- R10: After reset, `busy`, `rd_en`, `res_valid`, `freq_valid`, all counts and `freq` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted when not busy |
| win_first | input | AW | First address of the window |
| win_last | input | AW | Last address of the window |
| zone | input | ZW | Nyquist zone number k |
| fsel | input | SW | Lane used for the frequency stage |
| rd_en | output | 1 | Memory read enable |
| rd_addr | output | AW | Memory read address |
| rd_data | input | NCH | Memory word, one cycle after the read |
| busy | output | 1 | Evaluation in progress |
| res_valid | output | 1 | Counts are valid |
| n_cnt | output | CW | Samples per lane in the window |
| ones_cnt | output | NCH*CW | Ones count per lane |
| trans_cnt | output | NCH*CW | Transition count per lane |
| dc_off | output | NCH | Duty cycle outside 47..53 % per lane |
| freq_valid | output | 1 | `freq` is valid |
| freq | output | ZW+1+FRAC | Folded frequency in units of fs/2 |

## Verification
The bench targets three boundaries. A window that wraps past the top address would collapse to a tiny count if the step wrapped wrongly, and a window covering all 2^AW words would report zero samples if n were narrowed. Lanes that toggle on every word, and lanes whose edges fall between words, catch a previous-sample register that is cleared per run or per row. Such a design counts a spurious first edge or misses edges.

Lanes with exactly 46, 47, 53 and 54 ones in 100 samples catch an off-by-one compare in the duty flag. Odd and even zones, with full-ratio and single-sample windows, catch an unfold with the wrong sign or a divide by zero. A second start issued mid-run catches a design that restarts or takes the new window.

// File: rtl/see_pkg.sv
package see_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_FLUSH = 2'd2,
    ST_CALC  = 2'd3
  } see_state_e;
endpackage

// File: rtl/see_seq.sv
module see_seq #(
  parameter int AW = 10,
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] first_i,
  input  logic [AW-1:0] last_i,
  input  logic          div_done,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          smp_vld,
  output logic          smp_first,
  output logic          load_res,
  output logic          busy,
  output logic [CW-1:0] n_res
);
  import see_pkg::*;

  see_state_e    state_q, state_d;
  logic [AW-1:0] cur_q, cur_d, last_q;
  logic          lead_q, lead_d;
  logic          vld_q, head_q, tail_q;
  logic [CW-1:0] ncnt_q, ncnt_d;
  logic          at_end, accept;

  assign rd_en   = (state_q == ST_READ);
  assign rd_addr = cur_q;
  assign at_end  = (cur_q == last_q);
  assign accept  = (state_q == ST_IDLE) && start;
  assign busy    = (state_q != ST_IDLE);
  assign smp_vld   = vld_q;
  assign smp_first = head_q;
  assign load_res  = vld_q && tail_q;

  always_comb begin
    state_d = state_q;
    cur_d   = cur_q;
    lead_d  = lead_q;
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_READ;
        cur_d   = first_i;
        lead_d  = 1'b1;
      end
      ST_READ: begin
        lead_d = 1'b0;
        if (at_end) state_d = ST_FLUSH;
        else        cur_d   = cur_q + 1'b1;
      end
      ST_FLUSH: state_d = ST_CALC;
      ST_CALC:  if (div_done) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    ncnt_d = ncnt_q;
    if (vld_q) ncnt_d = head_q ? CW'(1) : ncnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      last_q  <= '0;
      lead_q  <= 1'b0;
      vld_q   <= 1'b0;
      head_q  <= 1'b0;
      tail_q  <= 1'b0;
      ncnt_q  <= '0;
      n_res   <= '0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      lead_q  <= lead_d;
      vld_q   <= rd_en;
      head_q  <= rd_en && lead_q;
      tail_q  <= rd_en && at_end;
      if (accept)   last_q <= last_i;
      if (vld_q)    ncnt_q <= ncnt_d;
      if (load_res) n_res  <= ncnt_d;
    end
  end
endmodule

// File: rtl/see_chan.sv
module see_chan #(
  parameter int CW = 11,
  localparam int PW = CW + 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_vld,
  input  logic          smp_first,
  input  logic          bit_i,
  input  logic          load_res,
  input  logic [CW-1:0] n_res,
  output logic [CW-1:0] ones_o,
  output logic [CW-1:0] trans_o,
  output logic          dc_off_o
);
  logic          prev_q;
  logic [CW-1:0] ones_q, ones_d, trans_q, trans_d;
  logic [PW-1:0] o100, n47, n53;

  always_comb begin
    ones_d  = smp_first ? CW'(bit_i) : ones_q + CW'(bit_i);
    trans_d = smp_first ? '0 : trans_q + CW'(bit_i ^ prev_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      ones_q  <= '0;
      trans_q <= '0;
      ones_o  <= '0;
      trans_o <= '0;
    end else begin
      if (smp_vld) begin
        prev_q  <= bit_i;
        ones_q  <= ones_d;
        trans_q <= trans_d;
      end
      if (load_res) begin
        ones_o  <= ones_d;
        trans_o <= trans_d;
      end
    end
  end

  assign o100     = PW'(ones_o) * PW'(100);
  assign n47      = PW'(n_res) * PW'(47);
  assign n53      = PW'(n_res) * PW'(53);
  assign dc_off_o = (o100 < n47) || (o100 > n53);
endmodule

// File: rtl/see_div.sv
module see_div #(
  parameter int CW   = 11,
  parameter int FRAC = 16,
  localparam int QB  = FRAC + 1,
  localparam int KW  = $clog2(QB + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [CW-1:0] num,
  input  logic [CW-1:0] den,
  output logic          done,
  output logic [QB-1:0] quot
);
  logic [CW:0]   rem_q, rem_sub;
  logic [CW-1:0] den_q;
  logic [QB-1:0] quot_q;
  logic [KW-1:0] cnt_q;
  logic          act_q, zero_q, ge;

  assign ge      = rem_q >= {1'b0, den_q};
  assign rem_sub = ge ? rem_q - {1'b0, den_q} : rem_q;
  assign quot    = zero_q ? '0 : quot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      den_q  <= '0;
      quot_q <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
      zero_q <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= act_q && (cnt_q == '0);
      if (go) begin
        rem_q  <= {1'b0, num};
        den_q  <= den;
        zero_q <= (den == '0);
        quot_q <= '0;
        cnt_q  <= KW'(QB - 1);
        act_q  <= 1'b1;
      end else if (act_q) begin
        quot_q <= {quot_q[QB-2:0], ge};
        rem_q  <= {rem_sub[CW-1:0], 1'b0};
        cnt_q  <= cnt_q - 1'b1;
        if (cnt_q == '0) act_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/stream_edge_eval.sv
module stream_edge_eval #(
  parameter int NCH  = 18,
  parameter int AW   = 10,
  parameter int ZW   = 4,
  parameter int FRAC = 16,
  localparam int CW  = AW + 1,
  localparam int SW  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int FW  = ZW + 1 + FRAC,
  localparam int QB  = FRAC + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AW-1:0]     win_first,
  input  logic [AW-1:0]     win_last,
  input  logic [ZW-1:0]     zone,
  input  logic [SW-1:0]     fsel,
  output logic              rd_en,
  output logic [AW-1:0]     rd_addr,
  input  logic [NCH-1:0]    rd_data,
  output logic              busy,
  output logic              res_valid,
  output logic [CW-1:0]     n_cnt,
  output logic [NCH*CW-1:0] ones_cnt,
  output logic [NCH*CW-1:0] trans_cnt,
  output logic [NCH-1:0]    dc_off,
  output logic              freq_valid,
  output logic [FW-1:0]     freq
);
  logic [1:0]    rsync_q;
  logic          rst_i_n;
  logic          smp_vld, smp_first, load_res, load_d, div_done, accept;
  logic [ZW-1:0] zone_q;
  logic [SW-1:0] sel_q;
  logic [QB-1:0] quot;
  logic [CW-1:0] trans_a [NCH];
  logic [FW-1:0] base_even, base_odd, freq_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  see_seq #(.AW(AW)) seq_i (
    .clk(clk), .rst_n(rst_i_n), .start(start),
    .first_i(win_first), .last_i(win_last), .div_done(div_done),
    .rd_en(rd_en), .rd_addr(rd_addr), .smp_vld(smp_vld),
    .smp_first(smp_first), .load_res(load_res), .busy(busy), .n_res(n_cnt)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [CW-1:0] ones_w, trans_w;
    see_chan #(.CW(CW)) chan_i (
      .clk(clk), .rst_n(rst_i_n), .smp_vld(smp_vld), .smp_first(smp_first),
      .bit_i(rd_data[c]), .load_res(load_res), .n_res(n_cnt),
      .ones_o(ones_w), .trans_o(trans_w), .dc_off_o(dc_off[c])
    );
    assign ones_cnt[c*CW +: CW]  = ones_w;
    assign trans_cnt[c*CW +: CW] = trans_w;
    assign trans_a[c]            = trans_w;
  end

  see_div #(.CW(CW), .FRAC(FRAC)) div_i (
    .clk(clk), .rst_n(rst_i_n), .go(load_d),
    .num(trans_a[sel_q]), .den(n_cnt - 1'b1),
    .done(div_done), .quot(quot)
  );

  assign accept    = start && !busy;
  assign base_even = {1'b0, zone_q, {FRAC{1'b0}}};
  assign base_odd  = {({1'b0, zone_q} + 1'b1), {FRAC{1'b0}}};
  assign freq_d    = zone_q[0] ? base_odd - FW'(quot) : base_even + FW'(quot);

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      zone_q     <= '0;
      sel_q      <= '0;
      load_d     <= 1'b0;
      res_valid  <= 1'b0;
      freq_valid <= 1'b0;
      freq       <= '0;
    end else begin
      load_d <= load_res;
      if (accept) begin
        zone_q     <= zone;
        sel_q      <= fsel;
        res_valid  <= 1'b0;
        freq_valid <= 1'b0;
      end
      if (load_res) res_valid <= 1'b1;
      if (div_done) begin
        freq       <= freq_d;
        freq_valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/see_chk.sv
module see_chk #(
  parameter int NCH = 18,
  parameter int AW  = 10,
  localparam int CW = AW + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic [AW-1:0]     rd_addr,
  input logic              busy,
  input logic              res_valid,
  input logic              freq_valid,
  input logic [CW-1:0]     n_cnt,
  input logic [NCH*CW-1:0] ones_cnt,
  input logic [NCH*CW-1:0] trans_cnt
);
  assert_addr_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && $past(rd_en)) |-> (rd_addr == AW'($past(rd_addr) + 1'b1)));

  assert_rd_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> busy);

  assert_n_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (n_cnt != '0) && (n_cnt <= CW'(1 << AW)));

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    assert_ones_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (ones_cnt[c*CW +: CW] <= n_cnt));
    assert_trans_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (trans_cnt[c*CW +: CW] < n_cnt));
  end

  assert_valid_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> (busy && !rd_en));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(res_valid)) |->
      ($stable(n_cnt) && $stable(ones_cnt) && $stable(trans_cnt)));

  assert_freq_after_R8: assert property (@(posedge clk) disable iff (!rst_n)
    freq_valid |-> res_valid);
endmodule

bind stream_edge_eval see_chk #(.NCH(NCH), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .busy(busy),
  .res_valid(res_valid), .freq_valid(freq_valid), .n_cnt(n_cnt),
  .ones_cnt(ones_cnt), .trans_cnt(trans_cnt)
);

// File: tb/stream_edge_eval_tb.sv
module stream_edge_eval_tb_top;
  localparam int NCH  = 18;
  localparam int AW   = 10;
  localparam int ZW   = 4;
  localparam int FRAC = 16;
  localparam int CW   = AW + 1;
  localparam int SW   = $clog2(NCH);
  localparam int FW   = ZW + 1 + FRAC;
  localparam int DEP  = 1 << AW;
  localparam int MASK = DEP - 1;

  logic clk, rst_n, start;
  logic [AW-1:0] win_first, win_last, rd_addr;
  logic [ZW-1:0] zone;
  logic [SW-1:0] fsel;
  logic rd_en, busy, res_valid, freq_valid;
  logic [NCH-1:0] rd_data, dc_off;
  logic [CW-1:0] n_cnt;
  logic [NCH*CW-1:0] ones_cnt, trans_cnt;
  logic [FW-1:0] freq;

  logic [NCH-1:0] mem [DEP];
  int checks = 0, errors = 0;
  int exp_ones [NCH];
  int exp_tr [NCH];
  bit finished = 0;

  stream_edge_eval #(.NCH(NCH), .AW(AW), .ZW(ZW), .FRAC(FRAC)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .win_first(win_first),
    .win_last(win_last), .zone(zone), .fsel(fsel), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .res_valid(res_valid),
    .n_cnt(n_cnt), .ones_cnt(ones_cnt), .trans_cnt(trans_cnt), .dc_off(dc_off),
    .freq_valid(freq_valid), .freq(freq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit gen(int mode, int a, int c, int base);
    int v;
    case (mode)
      0: begin v = a * 73 + c * 151 + ((a * a) >> 3); return v[4] ^ v[7]; end
      1: return (a % (2 + c)) < ((2 + c) / 2);
      2: return ((a - base) & MASK) < (40 + c);
      default: return a[0] ^ c[0];
    endcase
  endfunction

  task automatic fill(int mode, int base);
    for (int a = 0; a < DEP; a++)
      for (int c = 0; c < NCH; c++) mem[a][c] = gen(mode, a, c, base);
  endtask

  task automatic expect_win(int f, int n);
    for (int c = 0; c < NCH; c++) begin
      exp_ones[c] = 0; exp_tr[c] = 0;
      for (int j = 0; j < n; j++) begin
        exp_ones[c] += mem[(f + j) & MASK][c];
        if (j > 0) exp_tr[c] += mem[(f + j) & MASK][c] ^ mem[(f + j - 1) & MASK][c];
      end
    end
  endtask

  task automatic pulse_start(int f, int l, int z, int ch);
    @(negedge clk);
    start = 1; win_first = AW'(f); win_last = AW'(l); zone = ZW'(z); fsel = SW'(ch);
    @(posedge clk); #1;
    start = 0;
  endtask

  task automatic check_results(int n, int z, int ch);
    longint q, fe;
    bit seq_ok = 1, flag_ok = 1;
    chk(n_cnt == CW'(n), "R2 sample count", n_cnt, n);
    for (int c = 0; c < NCH; c++) begin
      chk(ones_cnt[c*CW +: CW] == CW'(exp_ones[c]), "R3 ones count", ones_cnt[c*CW +: CW], exp_ones[c]);
      chk(trans_cnt[c*CW +: CW] == CW'(exp_tr[c]), "R4 transition count", trans_cnt[c*CW +: CW], exp_tr[c]);
      if (dc_off[c] != ((100 * exp_ones[c] < 47 * n) || (100 * exp_ones[c] > 53 * n))) flag_ok = 0;
    end
    chk(flag_ok, "R7 duty flags", dc_off, 0);
    for (int w = 0; w < 100 && !freq_valid; w++) begin @(posedge clk); #1; end
    chk(freq_valid, "R8 freq_valid", freq_valid, 1);
    q  = (n == 1) ? 0 : (longint'(exp_tr[ch]) << FRAC) / (n - 1);
    fe = (z % 2) ? ((longint'(z + 1) << FRAC) - q) : ((longint'(z) << FRAC) + q);
    chk(freq == FW'(fe), (n == 1) ? "R9 single-sample freq" : "R8 folded freq", freq, fe);
    if (seq_ok) ;
  endtask

  task automatic run(int f, int l, int z, int ch);
    int n;
    bit addr_ok = 1, vld_ok = 1;
    n = ((l - f) & MASK) + 1;
    expect_win(f, n);
    pulse_start(f, l, z, ch);
    for (int k = 1; k <= n + 2; k++) begin
      if (k > 1) begin @(posedge clk); #1; end
      if (k <= n) begin
        if (!rd_en || rd_addr != AW'((f + k - 1) & MASK)) addr_ok = 0;
      end else if (rd_en) addr_ok = 0;
      if (k <= n + 1 && res_valid) vld_ok = 0;
      if (k == n + 2 && !res_valid) vld_ok = 0;
    end
    chk(addr_ok, "R1 read sequence", rd_addr, (l & MASK));
    chk(vld_ok, "R5 result timing", res_valid, 1);
    check_results(n, z, ch);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; start = 0; win_first = '0; win_last = '0; zone = '0; fsel = '0;
    fill(0, 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (5) @(posedge clk);
    #1;
    // R10 reset state
    chk(!busy && !rd_en && !res_valid && !freq_valid, "R10 reset flags", {busy, rd_en, res_valid, freq_valid}, 0);
    chk(n_cnt == 0 && ones_cnt == 0 && trans_cnt == 0 && freq == 0, "R10 reset values", n_cnt, 0);

    run(10, 200, 0, 3);         // pseudo-random, even zone
    fill(1, 0);
    run(500, 530, 3, 5);        // square waves, odd zone
    fill(0, 0);
    run(1000, 20, 2, 17);       // wrap around top address
    fill(1, 0);
    run(0, 1023, 1, 0);         // full memory
    run(600, 599, 6, 9);        // last one below first: full memory
    fill(3, 0);
    run(40, 140, 4, 1);         // toggle every word: ratio 1, edges across rows
    run(41, 140, 7, 2);         // odd zone with full ratio
    run(77, 77, 5, 2);          // R9 single sample, odd zone
    run(77, 77, 4, 2);          // R9 single sample, even zone
    run(300, 301, 0, 4);        // two samples
    fill(2, 300);
    run(300, 399, 2, 7);        // R7 flag boundaries 46/47/53/54 per 100

    // R6: second start while busy is ignored
    fill(0, 0);
    begin
      int n;
      n = 120;
      expect_win(200, n);
      pulse_start(200, 319, 3, 6);
      chk(!res_valid, "R5 valid cleared on start", res_valid, 0);
      repeat (10) @(posedge clk);
      pulse_start(5, 9, 2, 1);
      for (int w = 0; w < 400 && !res_valid; w++) begin @(posedge clk); #1; end
      chk(res_valid, "R6 run completed", res_valid, 1);
      check_results(n, 3, 6);
      repeat (30) @(posedge clk);
      #1 chk(!busy, "R6 no restart", busy, 0);
      chk(n_cnt == CW'(n), "R6 results held", n_cnt, n);
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule